// File: doc/BRIEF.md
# Command ring header validator

This block decides whether a command ring in video memory may be enabled. The ring fills the top 64 KiB of the memory, so its base byte address is the memory size minus 0x10000. Software writes a config-done value to start the block. If that value is nonzero, the block reads the four 32-bit header words of the ring through a synchronous read port that has one cycle of latency. The words are min, max, next-command and stop, read in that order. The block then checks them against four rules and reports a one-cycle verdict together with done. It also keeps a level flag that tells later logic whether the ring configuration is currently valid. If the config-done value is zero, the flag is cleared and memory is not read.

The sequencer uses five named states:
- ST_IDLE waits for a config-done write. A nonzero write moves it to ST_REQ. A zero write stays in ST_IDLE and clears the flag.
- ST_REQ issues one read request and always moves to ST_WAIT.
- ST_WAIT captures the returned word. It goes back to ST_REQ for the next word, or moves to ST_EVAL after the fourth word.
- ST_EVAL registers the rule result and the flag, then moves to ST_REPORT.
- ST_REPORT drives done and the verdict for one cycle, then returns to ST_IDLE.

Any config-done write that arrives outside ST_IDLE is ignored.

Top module: `ring_hdr_check`

## Requirements
- R1: While reset is held and right after it is released, rd_req_o, busy_o, done_o, valid_o, reject_o and cfg_ok_o are all 0.
- R2: A config-done write with a nonzero value, taken while idle, produces exactly four read requests. Each request lasts one cycle, and no two requests are in adjacent cycles. The requests go to byte addresses BASE, BASE+4, BASE+8 and BASE+12 in that order, where BASE = MEM_BYTES − 0x10000.
- R3: busy_o rises in the cycle after the accepted write and stays high through the done cycle. done_o is high for one cycle, nine clock edges after the edge that accepted the write, and exactly one of valid_o or reject_o is high with it. busy_o is low in the cycle after done.
- R4: The ring is rejected if any of the four header words has a nonzero value in its low two bits.
- R5: The ring is rejected if min is below 16. min equal to 16 is accepted.
- R6: The ring is rejected if max is above 0x10000. max equal to 0x10000 is accepted.
- R7: The ring is rejected if max is below min + 10240. The sum is computed without wraparound, and max exactly equal to min + 10240 is accepted.
- R8: cfg_ok_o is 1 in the done cycle of a passing check and stays 1 until it is cleared. It is 0 in the done cycle of a rejected check.
- R9: A config-done write with value zero, taken while idle, sets cfg_ok_o to 0 in the next cycle. It raises neither busy_o nor done_o and issues no read request.
- R10: A config-done write made while busy_o is high, whatever its value, is ignored. It causes no extra read, no second done pulse and no change to cfg_ok_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | One-cycle config-done write strobe |
| cfg_val_i | input | DATA_W | Value carried by the config-done write |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_data_i | input | DATA_W | Read data, valid one cycle after the request |
| busy_o | output | 1 | A header check is in progress |
| done_o | output | 1 | One-cycle end-of-check pulse |
| valid_o | output | 1 | Header accepted (only with done_o) |
| reject_o | output | 1 | Header rejected (only with done_o) |
| cfg_ok_o | output | 1 | Level flag: ring configuration valid |

## Verification
The bench puts exact boundary values on each rule. It uses min of 12 and 16, max of 0x10000 and 0x10004, and a span of exactly 10240 against a span one word short. A design with an off-by-one comparison accepts or rejects the wrong one of each pair. It also uses a min near 2^32, for which a span sum that wraps in 32 bits would wrongly pass. Misalignment is placed in each word separately, including the next and stop words, which feed no range check. A design that dropped one of those words from the alignment test would then accept the ring. The bench also sends a zero write and writes made during a busy check. A design that clears the flag too late, reads memory on a zero write, or restarts during a check would show extra requests, a second done pulse or the wrong flag level.

// File: rtl/ring_hdr_pkg.sv
package ring_hdr_pkg;

    // Number of header words and their fixed slot order in the ring.
    localparam int unsigned HDR_WORDS  = 4;
    localparam int unsigned IDX_W      = $clog2(HDR_WORDS);
    localparam int unsigned WORD_SHIFT = 2;
    localparam int unsigned HDR_BYTES  = HDR_WORDS << WORD_SHIFT;

    localparam int unsigned SLOT_MIN  = 0;
    localparam int unsigned SLOT_MAX  = 1;
    localparam int unsigned SLOT_NEXT = 2;
    localparam int unsigned SLOT_STOP = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EVAL,
        ST_REPORT
    } seq_state_e;

endpackage

// File: rtl/ring_hdr_seq.sv
module ring_hdr_seq
    import ring_hdr_pkg::*;
#(
    parameter int unsigned WORDS = HDR_WORDS,
    parameter int unsigned IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          nz_i,
    input  logic          pass_i,
    output logic          rd_req_o,
    output logic          cap_en_o,
    output logic [IW-1:0] idx_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          valid_o,
    output logic          reject_o,
    output logic          cfg_ok_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [IW-1:0] idx_q;
    logic          pass_q;
    logic          cfg_ok_q;
    logic          last_word;
    logic          accept_go;
    logic          accept_clr;

    assign last_word  = (idx_q == LAST_IDX);
    assign accept_go  = (state_q == ST_IDLE) && go_i && nz_i;
    assign accept_clr = (state_q == ST_IDLE) && go_i && !nz_i;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept_go) state_d = ST_REQ;
            ST_REQ:    state_d = ST_WAIT;
            ST_WAIT:   state_d = last_word ? ST_EVAL : ST_REQ;
            ST_EVAL:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word index: cleared on accept, advanced after each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept_go) begin
            idx_q <= '0;
        end else if (state_q == ST_WAIT && !last_word) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Verdict and configuration flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q   <= 1'b0;
            cfg_ok_q <= 1'b0;
        end else if (accept_clr) begin
            cfg_ok_q <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            pass_q   <= pass_i;
            cfg_ok_q <= pass_i;
        end
    end

    // Outputs
    always_comb begin
        rd_req_o = 1'b0;
        cap_en_o = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        valid_o  = 1'b0;
        reject_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_REQ:    rd_req_o = 1'b1;
            ST_WAIT:   cap_en_o = 1'b1;
            ST_EVAL:   ;
            ST_REPORT: begin
                done_o   = 1'b1;
                valid_o  = pass_q;
                reject_o = !pass_q;
            end
            default:   busy_o = 1'b0;
        endcase
    end

    assign idx_o    = idx_q;
    assign cfg_ok_o = cfg_ok_q;

endmodule

// File: rtl/ring_hdr_store.sv
module ring_hdr_store
    import ring_hdr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IW     = IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en_i,
    input  logic [IW-1:0]             idx_i,
    input  logic [DATA_W-1:0]         data_i,
    output logic [DATA_W-1:0]         min_o,
    output logic [DATA_W-1:0]         max_o,
    output logic [HDR_WORDS-1:0][1:0] low_o
);

    // min and max need full width for the range rules; next and stop
    // only feed the alignment rule, so only their low bits are kept.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_slot
        logic hit;
        assign hit = cap_en_i && (idx_i == IW'(g));

        if (g == SLOT_MIN || g == SLOT_MAX) begin : g_full
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (hit) begin
                    word_q <= data_i;
                end
            end
            assign low_o[g] = word_q[1:0];
            if (g == SLOT_MIN) begin : g_min
                assign min_o = word_q;
            end else begin : g_max
                assign max_o = word_q;
            end
        end else begin : g_low
            logic [1:0] low_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_q <= '0;
                end else if (hit) begin
                    low_q <= data_i[1:0];
                end
            end
            assign low_o[g] = low_q;
        end
    end

endmodule

// File: rtl/ring_hdr_rules.sv
module ring_hdr_rules
    import ring_hdr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RING_BYTES = 32'h0001_0000,
    parameter int unsigned MIN_SPAN   = 10240
) (
    input  logic [DATA_W-1:0]         min_i,
    input  logic [DATA_W-1:0]         max_i,
    input  logic [HDR_WORDS-1:0][1:0] low_i,
    output logic                      pass_o
);

    localparam int unsigned XW = DATA_W + 1;

    logic [HDR_WORDS-1:0] misaligned;
    logic [XW-1:0]        min_x;
    logic [XW-1:0]        max_x;
    logic [XW-1:0]        span_floor;
    logic                 align_ok;
    logic                 min_ok;
    logic                 max_ok;
    logic                 span_ok;

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_align
        assign misaligned[g] = |low_i[g];
    end

    assign min_x      = {1'b0, min_i};
    assign max_x      = {1'b0, max_i};
    assign span_floor = min_x + XW'(MIN_SPAN);

    assign align_ok = ~|misaligned;
    assign min_ok   = (min_x >= XW'(HDR_BYTES));
    assign max_ok   = (max_x <= XW'(RING_BYTES));
    assign span_ok  = (max_x >= span_floor);

    assign pass_o = align_ok && min_ok && max_ok && span_ok;

endmodule

// File: rtl/ring_hdr_check.sv
module ring_hdr_check
    import ring_hdr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned MEM_BYTES  = 32'h0010_0000,
    parameter int unsigned RING_BYTES = 32'h0001_0000,
    parameter int unsigned MIN_SPAN   = 10240,
    parameter int unsigned ADDR_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [DATA_W-1:0] cfg_val_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              reject_o,
    output logic              cfg_ok_o
);

    localparam logic [ADDR_W-1:0] RING_BASE = ADDR_W'(MEM_BYTES - RING_BYTES);

    logic                      cap_en;
    logic [IDX_W-1:0]          idx;
    logic                      pass;
    logic [DATA_W-1:0]         hdr_min;
    logic [DATA_W-1:0]         hdr_max;
    logic [HDR_WORDS-1:0][1:0] hdr_low;

    ring_hdr_seq #(
        .WORDS (HDR_WORDS),
        .IW    (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (cfg_wr_i),
        .nz_i     (|cfg_val_i),
        .pass_i   (pass),
        .rd_req_o (rd_req_o),
        .cap_en_o (cap_en),
        .idx_o    (idx),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .valid_o  (valid_o),
        .reject_o (reject_o),
        .cfg_ok_o (cfg_ok_o)
    );

    ring_hdr_store #(
        .DATA_W (DATA_W),
        .IW     (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en_i (cap_en),
        .idx_i    (idx),
        .data_i   (rd_data_i),
        .min_o    (hdr_min),
        .max_o    (hdr_max),
        .low_o    (hdr_low)
    );

    ring_hdr_rules #(
        .DATA_W     (DATA_W),
        .RING_BYTES (RING_BYTES),
        .MIN_SPAN   (MIN_SPAN)
    ) u_rules (
        .min_i  (hdr_min),
        .max_i  (hdr_max),
        .low_i  (hdr_low),
        .pass_o (pass)
    );

    assign rd_addr_o = RING_BASE + ADDR_W'({idx, WORD_SHIFT'(0)});

endmodule

// File: rtl/ring_hdr_check_sva.sv
module ring_hdr_check_sva #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned MEM_BYTES  = 32'h0010_0000,
    parameter int unsigned RING_BYTES = 32'h0001_0000,
    parameter int unsigned ADDR_W     = $clog2(MEM_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic [DATA_W-1:0] cfg_val_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              valid_o,
    input logic              reject_o,
    input logic              cfg_ok_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MEM_BYTES - RING_BYTES);
    localparam logic [ADDR_W-1:0] TOP  = BASE + ADDR_W'(12);

    assert_req_in_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (busy_o && rd_addr_o >= BASE && rd_addr_o <= TOP && rd_addr_o[1:0] == 2'b00));

    assert_req_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valid_o ^ reject_o));

    assert_verdict_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || reject_o) |-> done_o);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_busy_ends_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    assert_pass_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cfg_ok_o);

    assert_reject_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> !cfg_ok_o);

    assert_zero_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !busy_o && cfg_val_i == '0) |=> (!cfg_ok_o && !busy_o && !rd_req_o));

    assert_busy_write_no_flag_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && $past(busy_o)) |-> $stable(cfg_ok_o) || $past(!busy_o));

endmodule

bind ring_hdr_check ring_hdr_check_sva #(
    .DATA_W     (DATA_W),
    .MEM_BYTES  (MEM_BYTES),
    .RING_BYTES (RING_BYTES),
    .ADDR_W     (ADDR_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_i  (cfg_wr_i),
    .cfg_val_i (cfg_val_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .reject_o  (reject_o),
    .cfg_ok_o  (cfg_ok_o)
);

// File: tb/ring_hdr_check_tb.sv
`timescale 1ns/1ps
module ring_hdr_check_tb;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned MEM_BYTES = 32'h0010_0000;
    localparam int unsigned ADDR_W    = 20;
    localparam int unsigned BASE      = MEM_BYTES - 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [DATA_W-1:0] cfg_val = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy, done, valid, reject, cfg_ok;

    logic [31:0] hdr [4];
    int unsigned mem_off;
    int          req_cnt = 0;
    int          addr_bad = 0;
    int          done_cnt = 0;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    ring_hdr_check u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_i  (cfg_wr),
        .cfg_val_i (cfg_val),
        .rd_req_o  (rd_req),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .busy_o    (busy),
        .done_o    (done),
        .valid_o   (valid),
        .reject_o  (reject),
        .cfg_ok_o  (cfg_ok)
    );

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (rd_req) begin
            mem_off = 32'(rd_addr) - BASE;
            if (mem_off < 16) rd_data <= hdr[mem_off >> 2];
            else              rd_data <= 32'hBAD0_BAD1;
        end
    end

    // Request and done monitor
    always @(negedge clk) begin
        if (rd_req) begin
            if (32'(rd_addr) != BASE + 32'(req_cnt) * 4) addr_bad++;
            req_cnt++;
        end
        if (done) done_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        req_cnt  = 0;
        addr_bad = 0;
        done_cnt = 0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {26'd0, rd_req, busy, done, valid, reject, cfg_ok}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {26'd0, rd_req, busy, done, valid, reject, cfg_ok}, 32'd0);
    endtask

    task automatic run_check(input logic [31:0] w_min, input logic [31:0] w_max,
                             input logic [31:0] w_next, input logic [31:0] w_stop,
                             input bit exp_pass, input string tag);
        int  n;
        bit  got;
        hdr[0] = w_min; hdr[1] = w_max; hdr[2] = w_next; hdr[3] = w_stop;
        @(negedge clk);
        clear_counts();
        cfg_wr = 1'b1; cfg_val = 32'h1;
        @(posedge clk);
        #1 cfg_wr = 1'b0; cfg_val = '0;
        n = 0; got = 0;
        while (!got && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) chk({"R3 busy after start ", tag}, 32'(busy), 32'd1);
            if (done) begin
                got = 1;
                chk({tag, " valid"}, 32'(valid), 32'(exp_pass));
                chk({tag, " reject"}, 32'(reject), 32'(!exp_pass));
                chk({"R8 flag at done ", tag}, 32'(cfg_ok), 32'(exp_pass));
            end
        end
        chk({"R3 done latency ", tag}, 32'(n), 32'd9);
        @(negedge clk);
        chk({"R3 busy low after done ", tag}, 32'(busy), 32'd0);
        chk({"R2 request count ", tag}, 32'(req_cnt), 32'd4);
        chk({"R2 request order ", tag}, 32'(addr_bad), 32'd0);
    endtask

    task automatic test_zero_clear();
        run_check(32'h10, 32'h10000, 32'h10, 32'h10, 1'b1, "R9 setup");
        @(negedge clk);
        clear_counts();
        cfg_wr = 1'b1; cfg_val = '0;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared", 32'(cfg_ok), 32'd0);
        chk("R9 no busy", 32'(busy), 32'd0);
        repeat (12) @(negedge clk);
        chk("R9 no reads", 32'(req_cnt), 32'd0);
        chk("R9 no done", 32'(done_cnt), 32'd0);
    endtask

    task automatic test_busy_ignore();
        hdr[0] = 32'h400; hdr[1] = 32'h8000; hdr[2] = 32'h500; hdr[3] = 32'h400;
        @(negedge clk);
        clear_counts();
        cfg_wr = 1'b1; cfg_val = 32'h1;
        @(posedge clk);
        #1 cfg_wr = 1'b0; cfg_val = '0;
        repeat (3) @(negedge clk);
        cfg_wr = 1'b1; cfg_val = '0;
        @(negedge clk);
        cfg_val = 32'h5;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_val = '0;
        repeat (24) @(negedge clk);
        chk("R10 single done", 32'(done_cnt), 32'd1);
        chk("R10 no extra reads", 32'(req_cnt), 32'd4);
        chk("R10 flag kept", 32'(cfg_ok), 32'd1);
        chk("R10 idle after", 32'(busy), 32'd0);
    endtask

    task automatic run_all();
        test_reset();
        run_check(32'h10, 32'h10000, 32'h10, 32'h10, 1'b1, "R5 R6 edge pass");
        run_check(32'h400, 32'h8000, 32'h500, 32'h400, 1'b1, "R8 mid pass");
        run_check(32'hC, 32'h10000, 32'h10, 32'h10, 1'b0, "R5 min 12");
        run_check(32'h10, 32'h10004, 32'h10, 32'h10, 1'b0, "R6 max over");
        run_check(32'h1000, 32'h3800, 32'h1000, 32'h1000, 1'b1, "R7 span exact");
        run_check(32'h1000, 32'h37FC, 32'h1000, 32'h1000, 1'b0, "R7 span short");
        run_check(32'hFFFF_FFF0, 32'h10000, 32'h10, 32'h10, 1'b0, "R7 no wrap");
        run_check(32'h11, 32'h10000, 32'h10, 32'h10, 1'b0, "R4 min misaligned");
        run_check(32'h10, 32'hFFFE, 32'h10, 32'h10, 1'b0, "R4 max misaligned");
        run_check(32'h10, 32'h10000, 32'h102, 32'h10, 1'b0, "R4 next misaligned");
        run_check(32'h10, 32'h10000, 32'h10, 32'h21, 1'b0, "R4 stop misaligned");
        test_zero_clear();
        test_busy_ignore();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule